// File: doc/BRIEF.md
# Host Buffer Access Path

This block gives a 16-bit host bus sequential access to frame buffers held in a shared word-wide memory. Each access path holds three host-visible registers. The host loads a frame number and a byte offset into a path, then streams words through that path's data register. The offset advances by one word after every data access.

Host reads of the data register are served from a holding register that the path fills ahead of time. Loading the offset, or reading a data word, starts a memory fetch of the word at the current position. Host writes to the data register are captured in a post-write register and written to memory afterwards. The path then fetches the word at the new position, so the holding register always reflects memory. While a path has a memory operation outstanding, any host access to that path is stalled with the wait line.

Two paths are built by default, and each keeps its own frame number, offset and holding register. They share one memory request/grant port through an arbiter that serves the paths in rotating order and keeps its choice until the grant arrives. The byte address sent to memory is `frame * 2048 + offset`.

Each path runs a three-state machine:
- `ST_READY`: nothing is outstanding.
- `ST_PREREAD`: a fetch is requested.
- `ST_POSTWR`: a posted write is requested.

Its transitions are:
- READY→PREREAD when the offset is written or a data word is read.
- READY→POSTWR when a data word is written.
- POSTWR→PREREAD when the write is granted.
- PREREAD→READY when the fetch is granted.

Top module: `hbap_top`

## Requirements
- R1: After reset no memory request is raised, and the frame register, the offset register and the data register of every path all read 0.
- R2: Register select codes are 0 for frame number (low FID_W bits), 1 for byte offset and 2 for data. Offset bit 0 is stored as 0. Code 3 reads 0, and writes to it change nothing.
- R3: Writing the offset, or reading the data register, starts a memory read of the word at byte address frame*2048+offset. The next data read returns that word.
- R4: A data write is posted. The word is written to memory at the offset in effect when the host wrote it.
- R5: Every data read or write advances the offset by 2 bytes, wrapping from 2046 to 0 within the same frame.
- R6: host_wait is high while the selected path has a memory operation outstanding. An access takes effect only on a clock edge where host_cs is high and host_wait is low.
- R7: Each path keeps its own frame, offset and holding register. An access to an idle path is not stalled by the other path's pending operation.
- R8: Once mem_req is raised it stays high, with mem_addr, mem_we and mem_wdata unchanged, until mem_gnt is seen. Read data is taken from mem_rdata in the grant cycle.
- R9: When both paths request, the arbiter serves one per grant, keeps the chosen path until its grant arrives, and serves both to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cs | input | 1 | Host access strobe, held until host_wait is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_path | input | PSEL_W | Path selected by the host |
| host_reg | input | 2 | Register select (0 frame, 1 offset, 2 data) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data of the selected register |
| host_wait | output | 1 | Stall for the selected path |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | FID_W+OFFS_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant; completes the access |

## Verification
A wrong state in a path shows at the ports within one data access. A missed fetch, a skipped increment or a wrong address returns the wrong word on the next data read. A lost post-write surfaces when the same offset is read back.

A state machine stuck outside READY appears immediately as host_wait that never drops. An arbiter that changes owner mid-request shows as mem_addr moving while mem_req waits for its grant. The bench varies the grant latency so that stalls, the wrap at offset 2046, and overlapping requests from both paths are all exercised.

// File: rtl/hbap_pkg.sv
package hbap_pkg;
    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_PREREAD = 2'd1,
        ST_POSTWR  = 2'd2
    } path_state_e;

    localparam logic [1:0] SEL_FRAME  = 2'd0;
    localparam logic [1:0] SEL_OFFSET = 2'd1;
    localparam logic [1:0] SEL_DATA   = 2'd2;
endpackage

// File: rtl/hbap_path.sv
module hbap_path
    import hbap_pkg::*;
#(
    parameter int FID_W  = 3,
    parameter int OFFS_W = 11,
    parameter int DATA_W = 16,
    localparam int ADDR_W = FID_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [1:0]        regsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wait_o,
    output logic              mreq,
    output logic              mwe,
    output logic [ADDR_W-1:0] maddr,
    output logic [DATA_W-1:0] mwdata,
    input  logic              mgnt,
    input  logic [DATA_W-1:0] mrdata
);
    path_state_e       state_q, state_d;
    logic [FID_W-1:0]  frame_q;
    logic [OFFS_W-1:0] offs_q;
    logic [DATA_W-1:0] hold_q, pw_data_q;
    logic [ADDR_W-1:0] pw_addr_q;
    logic              acc, acc_data, acc_offs_wr;

    assign acc         = sel && !wait_o;
    assign acc_data    = acc && (regsel == SEL_DATA);
    assign acc_offs_wr = acc && we && (regsel == SEL_OFFSET);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (acc_offs_wr || (acc_data && !we)) state_d = ST_PREREAD;
                else if (acc_data && we)              state_d = ST_POSTWR;
            end
            ST_PREREAD: if (mgnt) state_d = ST_READY;
            ST_POSTWR:  if (mgnt) state_d = ST_PREREAD;
            default:    state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        wait_o = sel && (state_q != ST_READY);
        mreq   = 1'b0;
        mwe    = 1'b0;
        maddr  = {frame_q, offs_q};
        mwdata = pw_data_q;
        unique case (state_q)
            ST_READY:   ;
            ST_PREREAD: mreq = 1'b1;
            ST_POSTWR: begin
                mreq  = 1'b1;
                mwe   = 1'b1;
                maddr = pw_addr_q;
            end
            default: ;
        endcase
        unique case (regsel)
            SEL_FRAME:  rdata = DATA_W'(frame_q);
            SEL_OFFSET: rdata = DATA_W'(offs_q);
            SEL_DATA:   rdata = hold_q;
            default:    rdata = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q   <= '0;
            offs_q    <= '0;
            hold_q    <= '0;
            pw_data_q <= '0;
            pw_addr_q <= '0;
        end else begin
            if (acc && we && (regsel == SEL_FRAME)) frame_q <= wdata[FID_W-1:0];
            if (acc_offs_wr) offs_q <= {wdata[OFFS_W-1:1], 1'b0};
            if (acc_data) begin
                offs_q <= offs_q + OFFS_W'(2);
                if (we) begin
                    pw_data_q <= wdata;
                    pw_addr_q <= {frame_q, offs_q};
                end
            end
            if (state_q == ST_PREREAD && mgnt) hold_q <= mrdata;
        end
    end

    a_r4_postwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_data && we) |=> (mreq && mwe && mwdata == $past(wdata)));

    a_r3_preread: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_offs_wr || (acc_data && !we)) |=> (mreq && !mwe));

    a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mreq && !mgnt) |=> $stable(offs_q) && $stable(frame_q));
endmodule

// File: rtl/hbap_arb.sv
module hbap_arb #(
    parameter int N = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             mem_gnt,
    output logic [IDX_W-1:0] cur,
    output logic [N-1:0]     gnt_vec,
    output logic             any_req
);
    logic [IDX_W-1:0] ptr_q, own_q, pick;
    logic             lock_q, found;

    always_comb begin
        pick  = ptr_q;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(ptr_q) + k) % N]) begin
                pick  = IDX_W'((int'(ptr_q) + k) % N);
                found = 1'b1;
            end
        end
        any_req = |req;
        cur     = lock_q ? own_q : pick;
        gnt_vec = '0;
        if (any_req && mem_gnt) gnt_vec[cur] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            own_q  <= '0;
            lock_q <= 1'b0;
        end else if (any_req && mem_gnt) begin
            lock_q <= 1'b0;
            ptr_q  <= IDX_W'((int'(cur) + 1) % N);
        end else if (any_req) begin
            lock_q <= 1'b1;
            own_q  <= cur;
        end
    end

    a_r9_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !mem_gnt) |=> (cur == $past(cur)));
endmodule

// File: rtl/hbap_top.sv
module hbap_top #(
    parameter int NPATH  = 2,
    parameter int FID_W  = 3,
    parameter int OFFS_W = 11,
    parameter int DATA_W = 16,
    localparam int PSEL_W = (NPATH > 1) ? $clog2(NPATH) : 1,
    localparam int ADDR_W = FID_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [PSEL_W-1:0] host_path,
    input  logic [1:0]        host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_wait,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt
);
    logic [NPATH-1:0]  p_req, p_we, p_wait, p_gnt;
    logic [ADDR_W-1:0] p_addr  [NPATH];
    logic [DATA_W-1:0] p_wdata [NPATH];
    logic [DATA_W-1:0] p_rdata [NPATH];
    logic [PSEL_W-1:0] cur;
    logic              any_req;

    for (genvar i = 0; i < NPATH; i++) begin : g_path
        hbap_path #(.FID_W(FID_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (host_cs && (host_path == PSEL_W'(i))),
            .we     (host_we),
            .regsel (host_reg),
            .wdata  (host_wdata),
            .rdata  (p_rdata[i]),
            .wait_o (p_wait[i]),
            .mreq   (p_req[i]),
            .mwe    (p_we[i]),
            .maddr  (p_addr[i]),
            .mwdata (p_wdata[i]),
            .mgnt   (p_gnt[i]),
            .mrdata (mem_rdata)
        );
    end

    hbap_arb #(.N(NPATH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (p_req),
        .mem_gnt (mem_gnt),
        .cur     (cur),
        .gnt_vec (p_gnt),
        .any_req (any_req)
    );

    assign mem_req    = any_req;
    assign mem_we     = p_we[cur];
    assign mem_addr   = p_addr[cur];
    assign mem_wdata  = p_wdata[cur];
    assign host_rdata = p_rdata[host_path];
    assign host_wait  = p_wait[host_path];

    a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/sim_hbap_top.sv
module sim_hbap_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_cs = 0, host_we = 0;
    logic [0:0]  host_path = 0;
    logic [1:0]  host_reg = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic        host_wait, mem_req, mem_we, mem_gnt;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0;
    int lat = 0, lat_cnt = 0;
    logic [15:0] mem     [8192];
    logic [15:0] ref_mem [8192];
    logic [15:0] exp_q[$], act_q[$];
    string       req_q[$];
    logic        pend_prev = 0;
    logic [13:0] addr_prev = 0;
    int          r8_bad = 0;

    always #5 clk = ~clk;

    hbap_top u0 (.*);

    function automatic logic [15:0] init_val(int i);
        return 16'(i * 37 + 16'h5a00);
    endfunction

    // memory model with variable grant latency
    assign mem_gnt   = mem_req && (lat_cnt == lat);
    assign mem_rdata = mem[mem_addr[13:1]];
    always @(posedge clk) begin
        if (mem_gnt && mem_we) mem[mem_addr[13:1]] <= mem_wdata;
        if (mem_req && !mem_gnt) lat_cnt <= lat_cnt + 1;
        else lat_cnt <= 0;
    end

    // R8: request held stable until granted
    always @(negedge clk) begin
        if (rst_n && pend_prev && (!mem_req || mem_addr != addr_prev)) r8_bad++;
        pend_prev <= mem_req && !mem_gnt;
        addr_prev <= mem_addr;
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [15:0] e, a;
            string r;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            r = req_q.pop_front();
            chk(a == e, r, a, e);
        end
    end

    task automatic host_op(input int p, input logic [1:0] r, input logic we,
                           input logic [15:0] d, output logic [15:0] q,
                           output int waits);
        @(negedge clk);
        host_cs = 1; host_path = p[0]; host_reg = r; host_we = we; host_wdata = d;
        waits = 0;
        #1;
        while (host_wait) begin
            waits++;
            @(negedge clk);
            #1;
        end
        q = host_rdata;
        @(posedge clk);
        #1;
        host_cs = 0; host_we = 0;
    endtask

    int fr[2], of[2];

    task automatic set_pos(input int p, input int f, input int o);
        logic [15:0] q; int w;
        host_op(p, 2'd0, 1, 16'(f), q, w);
        host_op(p, 2'd1, 1, 16'(o), q, w);
        fr[p] = f; of[p] = o & 2046;
    endtask

    task automatic read_data(input int p, input string r, output int w);
        logic [15:0] q;
        exp_q.push_back(ref_mem[fr[p] * 1024 + of[p] / 2]);
        req_q.push_back(r);
        host_op(p, 2'd2, 0, 16'h0, q, w);
        act_q.push_back(q);
        of[p] = (of[p] + 2) % 2048;
    endtask

    task automatic write_data(input int p, input logic [15:0] d, output int w);
        logic [15:0] q;
        host_op(p, 2'd2, 1, d, q, w);
        ref_mem[fr[p] * 1024 + of[p] / 2] = d;
        of[p] = (of[p] + 2) % 2048;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int w;
        for (int i = 0; i < 8192; i++) begin
            mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(mem_req == 0, "R1 no request", mem_req, 0);
        host_op(0, 2'd0, 0, 0, q, w); chk(q == 0, "R1 frame", q, 0);
        host_op(0, 2'd1, 0, 0, q, w); chk(q == 0, "R1 offset", q, 0);
        host_op(1, 2'd2, 0, 0, q, w); chk(q == 0, "R1 data", q, 0);

        // R3 R5 sequential reads
        lat = 2;
        set_pos(0, 2, 10);
        for (int i = 0; i < 4; i++) read_data(0, "R3 R5 sequential read", w);
        host_op(0, 2'd1, 0, 0, q, w); chk(q == 18, "R5 offset advance", q, 18);

        // R2 offset bit 0 and unused code
        host_op(0, 2'd1, 1, 16'd7, q, w);
        host_op(0, 2'd1, 0, 0, q, w); chk(q == 6, "R2 offset bit0", q, 6);
        host_op(0, 2'd3, 1, 16'hffff, q, w);
        host_op(0, 2'd3, 0, 0, q, w); chk(q == 0, "R2 code3 reads 0", q, 0);
        host_op(0, 2'd0, 0, 0, q, w); chk(q == 2, "R2 frame unchanged", q, 2);
        host_op(0, 2'd1, 0, 0, q, w); chk(q == 6, "R2 offset unchanged", q, 6);

        // R4 R6 posted writes, then readback
        lat = 3;
        set_pos(0, 3, 100);
        write_data(0, 16'hA1A1, w);
        write_data(0, 16'hB2B2, w);
        chk(w > 0, "R6 wait on pending write", w, 1);
        write_data(0, 16'hC3C3, w);
        set_pos(0, 3, 100);
        for (int i = 0; i < 3; i++) read_data(0, "R4 posted write readback", w);
        set_pos(0, 3, 98);
        read_data(0, "R4 neighbour untouched", w);
        chk(w > 0, "R6 wait after offset load", w, 1);

        // R5 wrap within frame
        set_pos(0, 4, 2046);
        read_data(0, "R5 last word", w);
        read_data(0, "R5 wrap to 0", w);
        host_op(0, 2'd1, 0, 0, q, w); chk(q == 2, "R5 offset after wrap", q, 2);

        // R7 R9 two paths overlapping
        lat = 4;
        set_pos(0, 1, 0);
        host_op(1, 2'd0, 1, 16'd5, q, w);
        chk(w == 0, "R7 idle path not stalled", w, 0);
        host_op(1, 2'd1, 1, 16'd20, q, w);
        fr[1] = 5; of[1] = 20;
        read_data(0, "R9 path0 served", w);
        read_data(1, "R9 path1 served", w);
        write_data(1, 16'h7E7E, w);
        read_data(0, "R7 path0 own offset", w);
        set_pos(1, 5, 22);
        read_data(1, "R7 path1 own write", w);
        host_op(0, 2'd0, 0, 0, q, w); chk(q == 1, "R7 path0 frame", q, 1);
        host_op(1, 2'd0, 0, 0, q, w); chk(q == 5, "R7 path1 frame", q, 5);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        chk(r8_bad == 0, "R8 request stable", r8_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule